// File: doc/BRIEF.md
# Cell Header Check-Byte Stage

This block sits in the transmit path of a cell-based link. Cells arrive one byte per accepted cycle, 53 bytes per cell. The first byte of each cell is flagged by a start marker, and a two-bit class tag says whether the cell carries user traffic, maintenance traffic or idle fill. The stage computes a CRC-8 over the four leading header bytes. When the configuration allows, it writes that check byte, optionally offset by a fixed coset value, into the fifth byte position. Every other byte leaves the stage unchanged, one clock after it entered.

Before the fifth byte of a user cell can be overwritten, the stage compares it with an expected marker. Upstream logic placed that marker there to prove that the datapath in between is intact. A mismatch latches a sticky error flag, which can raise an interrupt. For equipment testing, a one-shot request corrupts the next inserted check byte.

An 8-bit control register holds the configuration and the error flag. Reading the register clears the flag.

Top module: `cell_hec_stage`

## Requirements
- R1: After reset the control register reads 0xF2, `irq` is low and `out_valid` is low.
- R2: Each accepted byte appears on `out_data` exactly one clock later, with `out_valid` high. `out_sop` marks byte 1 of a cell. Bytes other than byte 5 are unchanged.
- R3: The check byte is the CRC-8 of cell bytes 1 to 4, processed MSB first. It uses generator x^8+x^2+x+1 (0x07), and the CRC is reset to zero at every start flag. For user (class 0) and maintenance (class 1) cells, byte 5 is replaced by this check byte when control bit 5 is set.
- R4: When control bit 6 is set, 0x55 is XORed onto the check byte before it is inserted.
- R5: When control bit 5 is clear, byte 5 of user and maintenance cells passes through unchanged.
- R6: For idle cells (class 2), insertion is governed by control bit 1 alone, with the same CRC and coset rules.
- R7: For user cells only, the incoming byte 5 is compared, before any overwrite, with 0x55 when control bit 4 is clear or with 0xAA when it is set. A mismatch sets status bit 0. Maintenance and idle cells never set it.
- R8: Status bit 0 stays set until a register read, and the read returns the bit as set. A read clears it unless a new mismatch arrives in the same cycle. Register writes update bits 7 to 1 only.
- R9: `irq` is high exactly when status bit 0 and control bit 2 are both set.
- R10: A pulse on `inj_req` XORs 0x01 onto the next inserted check byte only. Later cells are unaffected.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Input byte valid |
| in_sop | input | 1 | Input byte is byte 1 of a cell |
| in_class | input | 2 | Cell class: 0 user, 1 maintenance, 2 idle (sampled with start) |
| in_data | input | 8 | Input byte |
| out_valid | output | 1 | Output byte valid |
| out_sop | output | 1 | Output byte is byte 1 of a cell |
| out_data | output | 8 | Output byte |
| reg_wr | input | 1 | Control register write strobe |
| reg_rd | input | 1 | Control register read strobe (clears status) |
| reg_wdata | input | 8 | Control register write data |
| reg_rdata | output | 8 | Control register contents |
| inj_req | input | 1 | One-shot check-byte error request |
| irq | output | 1 | Integrity-error interrupt |

## Verification
A wrong byte counter or a CRC that is not cleared shows up as a wrong byte 5 on the output one clock after byte 5 enters. The same fault in a following cell shows it again at the same position. A lost or stuck error flag is seen at the next register read and at `irq`, within a cycle of the offending byte 5. A pending injection that is never consumed, or consumed twice, makes byte 5 of the following inserted cell differ by exactly 0x01.

// File: rtl/hec_pkg.sv
package hec_pkg;

    localparam int          BYTE_W     = 8;
    localparam int          CELL_BYTES = 53;
    localparam int          HDR_BYTES  = 4;
    localparam int          HEC_POS    = 4;
    localparam int          IDX_W      = $clog2(CELL_BYTES + 1);
    localparam logic [7:0]  CRC_POLY   = 8'h07;
    localparam logic [7:0]  COSET_VAL  = 8'h55;
    localparam logic [7:0]  MARK_LO    = 8'h55;
    localparam logic [7:0]  MARK_HI    = 8'hAA;
    localparam logic [7:0]  INJ_MASK   = 8'h01;
    localparam logic [7:0]  CTRL_RST   = 8'hF2;

    typedef enum logic [1:0] {
        CLS_USER = 2'd0,
        CLS_MAINT = 2'd1,
        CLS_IDLE = 2'd2,
        CLS_RSVD = 2'd3
    } cell_class_e;

    typedef struct packed {
        logic scr_en;
        logic coset_en;
        logic hec_ins_en;
        logic mark_sel;
        logic gfc_en;
        logic irq_en;
        logic idle_hec_en;
        logic err_sts;
    } ctrl_t;

    function automatic logic [BYTE_W-1:0] crc8_step(input logic [BYTE_W-1:0] crc,
                                                    input logic [BYTE_W-1:0] d);
        logic [BYTE_W-1:0] c;
        c = crc;
        for (int i = BYTE_W - 1; i >= 0; i--) begin
            if (c[BYTE_W-1] ^ d[i])
                c = {c[BYTE_W-2:0], 1'b0} ^ CRC_POLY;
            else
                c = {c[BYTE_W-2:0], 1'b0};
        end
        return c;
    endfunction

endpackage

// File: rtl/hec_ctrl_reg.sv
module hec_ctrl_reg
    import hec_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              wr,
    input  logic              rd,
    input  logic [BYTE_W-1:0] wdata,
    input  logic              set_err,
    output ctrl_t             ctrl,
    output logic              irq
);

    ctrl_t ctrl_q;
    ctrl_t ctrl_d;

    always_comb begin
        ctrl_d = ctrl_q;
        if (wr)
            ctrl_d = ctrl_t'(wdata);
        if (set_err)
            ctrl_d.err_sts = 1'b1;
        else if (rd)
            ctrl_d.err_sts = 1'b0;
        else
            ctrl_d.err_sts = ctrl_q.err_sts;
    end

    always_ff @(posedge clk) begin
        if (rst)
            ctrl_q <= ctrl_t'(CTRL_RST);
        else
            ctrl_q <= ctrl_d;
    end

    assign ctrl = ctrl_q;
    assign irq  = ctrl_q.err_sts & ctrl_q.irq_en;

    AST_STS_STICKY: assert property (@(posedge clk) disable iff (rst)
        (ctrl_q.err_sts && !rd) |=> ctrl_q.err_sts); // R8
    AST_STS_CLEAR: assert property (@(posedge clk) disable iff (rst)
        (rd && !set_err) |=> !ctrl_q.err_sts); // R8
    AST_STS_SET: assert property (@(posedge clk) disable iff (rst)
        set_err |=> ctrl_q.err_sts); // R7
    AST_WR_NO_STS: assert property (@(posedge clk) disable iff (rst)
        (wr && !set_err && !ctrl_q.err_sts) |=> !ctrl_q.err_sts); // R8

endmodule

// File: rtl/hec_crc_acc.sv
module hec_crc_acc
    import hec_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              in_valid,
    input  logic              in_sop,
    input  cell_class_e       in_class,
    input  logic [BYTE_W-1:0] in_data,
    output logic [IDX_W-1:0]  idx_cur,
    output cell_class_e       cls_cur,
    output logic [BYTE_W-1:0] crc_cur
);

    localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(CELL_BYTES);
    localparam logic [IDX_W-1:0] HDR_END  = IDX_W'(HDR_BYTES);

    logic [IDX_W-1:0]  idx_q;
    cell_class_e       cls_q;
    logic [BYTE_W-1:0] crc_q;

    assign idx_cur = in_sop ? '0 : idx_q;
    assign cls_cur = in_sop ? in_class : cls_q;
    assign crc_cur = in_sop ? '0 : crc_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            idx_q <= LAST_IDX;
            cls_q <= CLS_USER;
            crc_q <= '0;
        end else if (in_valid) begin
            idx_q <= (idx_cur == LAST_IDX) ? idx_cur : idx_cur + 1'b1;
            cls_q <= cls_cur;
            crc_q <= (idx_cur < HDR_END) ? crc8_step(crc_cur, in_data) : crc_cur;
        end
    end

    AST_SOP_IDX: assert property (@(posedge clk) disable iff (rst)
        (in_valid && in_sop) |=> (idx_q == IDX_W'(1))); // R3
    AST_CRC_FREEZE: assert property (@(posedge clk) disable iff (rst)
        (in_valid && !in_sop && idx_q >= HDR_END) |=> $stable(crc_q)); // R3

endmodule

// File: rtl/cell_hec_stage.sv
module cell_hec_stage
    import hec_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              in_valid,
    input  logic              in_sop,
    input  logic [1:0]        in_class,
    input  logic [BYTE_W-1:0] in_data,
    output logic              out_valid,
    output logic              out_sop,
    output logic [BYTE_W-1:0] out_data,
    input  logic              reg_wr,
    input  logic              reg_rd,
    input  logic [BYTE_W-1:0] reg_wdata,
    output logic [BYTE_W-1:0] reg_rdata,
    input  logic              inj_req,
    output logic              irq
);

    localparam logic [IDX_W-1:0] HEC_IDX = IDX_W'(HEC_POS);

    ctrl_t             ctrl;
    logic [IDX_W-1:0]  idx_cur;
    cell_class_e       cls_cur;
    logic [BYTE_W-1:0] crc_cur;
    logic              at_hec;
    logic              ins_en;
    logic              mismatch;
    logic              consume;
    logic              inj_pend;
    logic [BYTE_W-1:0] mark;
    logic [BYTE_W-1:0] hec_val;

    hec_crc_acc u_acc (
        .clk      (clk),
        .rst      (rst),
        .in_valid (in_valid),
        .in_sop   (in_sop),
        .in_class (cell_class_e'(in_class)),
        .in_data  (in_data),
        .idx_cur  (idx_cur),
        .cls_cur  (cls_cur),
        .crc_cur  (crc_cur)
    );

    hec_ctrl_reg u_reg (
        .clk     (clk),
        .rst     (rst),
        .wr      (reg_wr),
        .rd      (reg_rd),
        .wdata   (reg_wdata),
        .set_err (mismatch),
        .ctrl    (ctrl),
        .irq     (irq)
    );

    assign reg_rdata = BYTE_W'(ctrl);
    assign mark      = ctrl.mark_sel ? MARK_HI : MARK_LO;
    assign at_hec    = in_valid && (idx_cur == HEC_IDX);
    assign ins_en    = (cls_cur == CLS_IDLE) ? ctrl.idle_hec_en : ctrl.hec_ins_en;
    assign mismatch  = at_hec && (cls_cur == CLS_USER) && (in_data != mark);
    assign consume   = at_hec && ins_en && inj_pend;
    assign hec_val   = crc_cur ^ (ctrl.coset_en ? COSET_VAL : '0)
                               ^ (inj_pend ? INJ_MASK : '0);

    always_ff @(posedge clk) begin
        if (rst)
            inj_pend <= 1'b0;
        else if (inj_req)
            inj_pend <= 1'b1;
        else if (consume)
            inj_pend <= 1'b0;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            out_valid <= 1'b0;
            out_sop   <= 1'b0;
            out_data  <= '0;
        end else begin
            out_valid <= in_valid;
            out_sop   <= in_valid && in_sop;
            out_data  <= (at_hec && ins_en) ? hec_val : in_data;
        end
    end

    AST_LATENCY: assert property (@(posedge clk) disable iff (rst)
        !$past(rst) |-> (out_valid == $past(in_valid))); // R2
    AST_PASS_BYTE: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && $past(in_valid) && !$past(at_hec)) |-> (out_data == $past(in_data))); // R2
    AST_INJ_ONCE: assert property (@(posedge clk) disable iff (rst)
        (consume && !inj_req) |=> !inj_pend); // R10
    AST_INJ_HOLD: assert property (@(posedge clk) disable iff (rst)
        (inj_pend && !consume) |=> inj_pend); // R10

endmodule

// File: tb/cell_hec_stage_bench.sv
`timescale 1ns/1ps
module cell_hec_stage_bench;

    localparam real HALF = 2.0;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       in_valid = 1'b0;
    logic       in_sop = 1'b0;
    logic [1:0] in_class = 2'd0;
    logic [7:0] in_data = 8'h00;
    logic       out_valid;
    logic       out_sop;
    logic [7:0] out_data;
    logic       reg_wr = 1'b0;
    logic       reg_rd = 1'b0;
    logic [7:0] reg_wdata = 8'h00;
    logic [7:0] reg_rdata;
    logic       inj_req = 1'b0;
    logic       irq;

    int n_chk = 0;
    int n_bad = 0;
    logic [7:0] cfg = 8'hF2;
    logic       exp_sts = 1'b0;
    logic       exp_pend = 1'b0;

    always #(HALF) clk = ~clk;

    cell_hec_stage u_cell_hec_stage (
        .clk(clk), .rst(rst), .in_valid(in_valid), .in_sop(in_sop),
        .in_class(in_class), .in_data(in_data), .out_valid(out_valid),
        .out_sop(out_sop), .out_data(out_data), .reg_wr(reg_wr),
        .reg_rd(reg_rd), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .inj_req(inj_req), .irq(irq)
    );

    task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [7:0] ref_crc(input logic [31:0] hdr);
        logic [39:0] r;
        r = {hdr, 8'h00};
        for (int i = 39; i >= 8; i--)
            if (r[i]) r[i -: 9] = r[i -: 9] ^ 9'h107;
        return r[7:0];
    endfunction

    task automatic wr_reg(input logic [7:0] v);
        @(negedge clk);
        reg_wr = 1'b1; reg_wdata = v;
        @(negedge clk);
        reg_wr = 1'b0;
        cfg = {v[7:1], 1'b0};
    endtask

    task automatic rd_reg();
        @(negedge clk);
        reg_rd = 1'b1;
        #0.5;
        check("R8 read", reg_rdata, {cfg[7:1], exp_sts});
        @(negedge clk);
        reg_rd = 1'b0;
        exp_sts = 1'b0;
    endtask

    task automatic inject();
        @(negedge clk);
        inj_req = 1'b1;
        @(negedge clk);
        inj_req = 1'b0;
        exp_pend = 1'b1;
    endtask

    task automatic send_cell(input logic [1:0] cls, input logic [31:0] hdr, input logic [7:0] b5);
        logic [7:0] b, e;
        logic ins;
        string tag;
        for (int j = 0; j < 53; j++) begin
            if (j < 4) b = hdr[31 - 8*j -: 8];
            else if (j == 4) b = b5;
            else b = 8'($urandom);
            e = b;
            tag = "R2";
            if (j == 4) begin
                ins = (cls == 2'd2) ? cfg[1] : cfg[5];
                if (ins) begin
                    e = ref_crc(hdr) ^ (cfg[6] ? 8'h55 : 8'h00) ^ (exp_pend ? 8'h01 : 8'h00);
                    tag = exp_pend ? "R10" : (cls == 2'd2) ? "R6" : cfg[6] ? "R4" : "R3";
                    exp_pend = 1'b0;
                end else begin
                    tag = (cls == 2'd2) ? "R6" : "R5";
                end
                if (cls == 2'd0 && b5 != (cfg[4] ? 8'hAA : 8'h55)) exp_sts = 1'b1;
            end
            @(negedge clk);
            in_valid = 1'b1; in_sop = (j == 0); in_class = cls; in_data = b;
            @(negedge clk);
            check("R2 valid", {7'd0, out_valid}, 8'd1);
            if (j == 0) check("R2 sop", {7'd0, out_sop}, 8'd1);
            check(tag, out_data, e);
            in_valid = 1'b0; in_sop = 1'b0;
        end
        check("R7 status", {7'd0, reg_rdata[0]}, {7'd0, exp_sts});
        check("R9 irq", {7'd0, irq}, {7'd0, exp_sts & cfg[2]});
    endtask

    task automatic finish_run();
        $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    endtask

    initial begin
        #(4.0 * 150000);
        n_chk++; n_bad++;
        $display("FAIL watchdog actual=%h expected=%h", 8'h01, 8'h00);
        finish_run();
    end

    initial begin
        void'($urandom(32'd1234));
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        check("R1 reg", reg_rdata, 8'hF2);
        check("R1 irq", {7'd0, irq}, 8'd0);
        check("R1 valid", {7'd0, out_valid}, 8'd0);

        // R3 R4: all-zero header gives the bare coset value
        send_cell(2'd0, 32'h0, 8'h55);
        // R3: coset off, alternate marker, matching byte
        wr_reg(8'hB2);
        send_cell(2'd0, 32'h01020304, 8'hAA);
        // R7: mismatch with irq disabled, then R9 with irq enabled
        send_cell(2'd0, 32'hDEADBEEF, 8'h55);
        wr_reg(8'hB6);
        check("R9 irq on", {7'd0, irq}, 8'd1);
        rd_reg();
        check("R8 cleared", {7'd0, irq}, 8'd0);
        rd_reg();
        // R5: insertion off, maintenance and idle mismatches ignored for R7
        wr_reg(8'h96);
        send_cell(2'd0, 32'h11223344, 8'hAA);
        send_cell(2'd1, 32'h55667788, 8'h3C);
        wr_reg(8'h94);
        send_cell(2'd2, 32'h00000001, 8'h6A);
        wr_reg(8'h96);
        send_cell(2'd2, 32'h00000001, 8'h6A);
        // R10: one corrupted cell then clean cells
        wr_reg(8'hE6);
        inject();
        send_cell(2'd1, 32'hCAFEF00D, 8'h55);
        send_cell(2'd1, 32'hCAFEF00D, 8'h55);

        for (int k = 0; k < 40; k++) begin
            logic [1:0] c;
            logic [7:0] b5;
            if ($urandom_range(0, 3) == 0) wr_reg(8'($urandom));
            if ($urandom_range(0, 4) == 0) inject();
            c = 2'($urandom_range(0, 2));
            b5 = ($urandom_range(0, 1) == 1) ? (cfg[4] ? 8'hAA : 8'h55) : 8'($urandom);
            send_cell(c, $urandom, b5);
            if ($urandom_range(0, 2) == 0) rd_reg();
        end
        rd_reg();
        finish_run();
    end

endmodule